// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the host-facing register front end of a three-channel interval timer. A host issues byte-wide reads and writes on a 2-bit address: addresses 0, 1 and 2 reach the data port of the matching channel, and address 3 is the control port. The block keeps each channel's access mode, operating mode and BCD flag. It also tracks the byte ordering used for reads and for writes, and it holds a count latch and a status latch for every channel. The counting engines sit outside this block.

The counting engines supply their live 16-bit counts and output levels. The block returns them to the host and drives a one-cycle load strobe, with the new initial count, whenever a full count has been written. A control byte with channel field 3 is a read-back command. It can freeze the count, the status, or both, for any subset of the channels in a single write. A frozen count or status is always returned before the channel's live count.

Top module: `tmr_host_regs`

## Requirements
- R1: After reset every channel is in word access (low byte then high byte), operating mode 3, binary. No load strobe is active. The first two reads of a channel return the low and then the high byte of its live count.
- R2: A control write with bits 7:6 equal to 0, 1 or 2 and a nonzero bits 5:4 stores that access mode for the channel. From the next cycle, `cfg_mode_o` shows bits 3:1 and `cfg_bcd_o` shows bit 0. The write also resets both byte sequencers of the channel to the low byte.
- R3: In access mode 1 (low only) a data write loads the byte as the count. In access mode 2 (high only) it loads the byte times 256. The matching `load_o` bit is high for exactly the one cycle after the write, and `load_val_o` carries the value in that cycle. No other channel's bit is high.
- R4: In access mode 3 the first data write only stores the low byte and drives no strobe. The next write loads {new byte, stored byte}.
- R5: A written count of zero is presented as 65536 (17-bit value 0x10000).
- R6: A control write with bits 5:4 = 0 latches the channel's live count. The following reads return the latched low byte (access 1), the high byte (access 2), or low then high (access 3). The latch is then released and live reads resume.
- R7: A latch command while a latched count is still unread has no effect.
- R8: A control write with bits 7:6 = 3 and bit 5 = 0 latches the count of every channel whose select bit is set: bit 1 for channel 0, bit 2 for channel 1, bit 3 for channel 2.
- R9: A read-back with bit 4 = 0 latches a status byte for each selected channel. The byte is {output level, 0, access[1:0], mode[2:0], bcd}. The next read of the channel returns the status ahead of any latched count. A pending status is not overwritten by a later read-back.
- R10: With no latch pending, live reads follow the channel's read sequence: low byte only, high byte only, or alternating low/high. This sequence advances independently of the write sequence.
- R11: A read of address 3 returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe (advances read state) |
| addr | input | 2 | Port address: 0 to 2 data, 3 control |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte for the current address |
| cnt_i | input | 48 | Live 16-bit count of each channel |
| out_lvl_i | input | 3 | Output level of each channel |
| load_o | output | 3 | One-cycle count-load strobe per channel |
| load_val_o | output | 51 | 17-bit load value per channel |
| cfg_mode_o | output | 9 | Operating mode per channel |
| cfg_bcd_o | output | 3 | BCD flag per channel |

## Verification
Data writes are tried in all three access modes, with the bench checking the load strobe and value for each. This separates low-only, high-only and two-byte assembly, and a zero byte pair confirms the 65536 case. Live reads are interleaved with a half-finished two-byte write, which shows whether the read and write sequences are truly separate. Latch commands are issued twice with the live count changed in between, to show that the first capture is kept and then released. A read-back that selects two channels, followed by a second status-only read-back, shows that status goes out before count and that a pending status is not overwritten.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_WORD  = 2'd3
  } acc_e;

  localparam logic [2:0] RESET_MODE = 3'd3;
endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode #(
  parameter int NUM_CH = 3
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [7:1]        ctl,
  output logic [NUM_CH-1:0] cfg_we,
  output logic [NUM_CH-1:0] latch_cnt,
  output logic [NUM_CH-1:0] latch_sts,
  output logic [NUM_CH-1:0] data_we,
  output logic [NUM_CH-1:0] data_re
);
  localparam logic [1:0] CTRL_ADDR = 2'd3;
  localparam logic [1:0] RB_SEL    = 2'd3;

  logic ctl_we;
  logic is_rb;
  logic acc_zero;

  assign ctl_we   = wr_en && (addr == CTRL_ADDR);
  assign is_rb    = (ctl[7:6] == RB_SEL);
  assign acc_zero = (ctl[5:4] == 2'd0);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit;
    logic rb_hit;
    assign hit          = (ctl[7:6] == 2'(i));
    assign rb_hit       = is_rb && ctl[i+1];
    assign cfg_we[i]    = ctl_we && hit && !acc_zero;
    assign latch_cnt[i] = ctl_we && ((hit && acc_zero) || (rb_hit && !ctl[5]));
    assign latch_sts[i] = ctl_we && rb_hit && !ctl[4];
    assign data_we[i]   = wr_en && (addr == 2'(i));
    assign data_re[i]   = rd_en && (addr == 2'(i));
  end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    wdata,
  input  logic          latch_cnt,
  input  logic          latch_sts,
  input  logic          data_we,
  input  logic          data_re,
  input  logic [CW-1:0] live_cnt,
  input  logic          out_lvl,
  output logic [7:0]    rdata,
  output logic          load_stb,
  output logic [CW:0]   load_val,
  output logic [2:0]    mode_o,
  output logic          bcd_o
);
  localparam int HB = CW - 8;
  localparam logic [CW:0] FULL_RANGE = (CW+1)'(1) << CW;

  acc_e          acc_q, acc_d;
  logic [2:0]    mode_q, mode_d;
  logic          bcd_q, bcd_d;
  logic          rd_hi_q, rd_hi_d;
  logic          wr_hi_q, wr_hi_d;
  logic [7:0]    low_q, low_d;
  acc_e          lat_st_q, lat_st_d;
  logic [CW-1:0] lat_q, lat_d;
  logic          sts_pend_q, sts_pend_d;
  logic [7:0]    sts_q, sts_d;
  logic          load_q, load_d;
  logic [CW:0]   lval_q, lval_d;
  logic [CW-1:0] raw;
  logic          do_load;

  // read data path
  always_comb begin
    if (sts_pend_q) begin
      rdata = sts_q;
    end else if (lat_st_q != ACC_LATCH) begin
      rdata = (lat_st_q == ACC_HI) ? lat_q[CW-1:HB] : lat_q[7:0];
    end else begin
      unique case (acc_q)
        ACC_HI:   rdata = live_cnt[CW-1:HB];
        ACC_WORD: rdata = rd_hi_q ? live_cnt[CW-1:HB] : live_cnt[7:0];
        default:  rdata = live_cnt[7:0];
      endcase
    end
  end

  // next state
  always_comb begin
    acc_d      = acc_q;
    mode_d     = mode_q;
    bcd_d      = bcd_q;
    rd_hi_d    = rd_hi_q;
    wr_hi_d    = wr_hi_q;
    low_d      = low_q;
    lat_st_d   = lat_st_q;
    lat_d      = lat_q;
    sts_pend_d = sts_pend_q;
    sts_d      = sts_q;
    lval_d     = lval_q;
    raw        = '0;
    do_load    = 1'b0;

    if (cfg_we) begin
      acc_d   = acc_e'(wdata[5:4]);
      mode_d  = wdata[3:1];
      bcd_d   = wdata[0];
      rd_hi_d = 1'b0;
      wr_hi_d = 1'b0;
    end

    if (data_we) begin
      unique case (acc_q)
        ACC_HI: begin
          raw     = {wdata, {HB{1'b0}}};
          do_load = 1'b1;
        end
        ACC_WORD: begin
          if (wr_hi_q) begin
            raw     = {wdata, {(HB-8){1'b0}}, low_q};
            do_load = 1'b1;
            wr_hi_d = 1'b0;
          end else begin
            low_d   = wdata;
            wr_hi_d = 1'b1;
          end
        end
        default: begin
          raw     = CW'(wdata);
          do_load = 1'b1;
        end
      endcase
    end

    if (do_load) begin
      lval_d = (raw == '0) ? FULL_RANGE : {1'b0, raw};
    end
    load_d = do_load;

    if (data_re) begin
      if (sts_pend_q) begin
        sts_pend_d = 1'b0;
      end else if (lat_st_q != ACC_LATCH) begin
        lat_st_d = (lat_st_q == ACC_WORD) ? ACC_HI : ACC_LATCH;
      end else if (acc_q == ACC_WORD) begin
        rd_hi_d = !rd_hi_q;
      end
    end

    if (latch_cnt && (lat_st_q == ACC_LATCH)) begin
      lat_d    = live_cnt;
      lat_st_d = acc_q;
    end

    if (latch_sts && !sts_pend_q) begin
      sts_d      = {out_lvl, 1'b0, acc_q, mode_q, bcd_q};
      sts_pend_d = 1'b1;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q      <= ACC_WORD;
      mode_q     <= RESET_MODE;
      bcd_q      <= 1'b0;
      rd_hi_q    <= 1'b0;
      wr_hi_q    <= 1'b0;
      low_q      <= '0;
      lat_st_q   <= ACC_LATCH;
      lat_q      <= '0;
      sts_pend_q <= 1'b0;
      sts_q      <= '0;
      load_q     <= 1'b0;
      lval_q     <= '0;
    end else begin
      acc_q      <= acc_d;
      mode_q     <= mode_d;
      bcd_q      <= bcd_d;
      rd_hi_q    <= rd_hi_d;
      wr_hi_q    <= wr_hi_d;
      low_q      <= low_d;
      lat_st_q   <= lat_st_d;
      lat_q      <= lat_d;
      sts_pend_q <= sts_pend_d;
      sts_q      <= sts_d;
      load_q     <= load_d;
      lval_q     <= lval_d;
    end
  end

  assign load_stb = load_q;
  assign load_val = lval_q;
  assign mode_o   = mode_q;
  assign bcd_o    = bcd_q;
endmodule

// File: rtl/tmr_host_regs.sv
module tmr_host_regs #(
  parameter int NUM_CH = 3,
  parameter int CW     = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [1:0]             addr,
  input  logic [7:0]             wdata,
  output logic [7:0]             rdata,
  input  logic [NUM_CH*CW-1:0]   cnt_i,
  input  logic [NUM_CH-1:0]      out_lvl_i,
  output logic [NUM_CH-1:0]      load_o,
  output logic [NUM_CH*(CW+1)-1:0] load_val_o,
  output logic [NUM_CH*3-1:0]    cfg_mode_o,
  output logic [NUM_CH-1:0]      cfg_bcd_o
);
  localparam int LW = CW + 1;

  logic [NUM_CH-1:0] cfg_we;
  logic [NUM_CH-1:0] latch_cnt;
  logic [NUM_CH-1:0] latch_sts;
  logic [NUM_CH-1:0] data_we;
  logic [NUM_CH-1:0] data_re;
  logic [7:0]        ch_rdata [NUM_CH];

  tmr_cmd_decode #(.NUM_CH(NUM_CH)) i_dec (
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .ctl       (wdata[7:1]),
    .cfg_we    (cfg_we),
    .latch_cnt (latch_cnt),
    .latch_sts (latch_sts),
    .data_we   (data_we),
    .data_re   (data_re)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    tmr_chan_regs #(.CW(CW)) i_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we[i]),
      .wdata     (wdata),
      .latch_cnt (latch_cnt[i]),
      .latch_sts (latch_sts[i]),
      .data_we   (data_we[i]),
      .data_re   (data_re[i]),
      .live_cnt  (cnt_i[i*CW +: CW]),
      .out_lvl   (out_lvl_i[i]),
      .rdata     (ch_rdata[i]),
      .load_stb  (load_o[i]),
      .load_val  (load_val_o[i*LW +: LW]),
      .mode_o    (cfg_mode_o[i*3 +: 3]),
      .bcd_o     (cfg_bcd_o[i])
    );
  end

  always_comb begin
    rdata = 8'hFF;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == 2'(i)) rdata = ch_rdata[i];
    end
  end
endmodule

// File: rtl/tmr_host_regs_chk.sv
module tmr_host_regs_chk #(
  parameter int NUM_CH = 3,
  parameter int CW     = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic [1:0]                addr,
  input logic [7:0]                wdata,
  input logic [7:0]                rdata,
  input logic [NUM_CH-1:0]         load_o,
  input logic [NUM_CH*(CW+1)-1:0]  load_val_o,
  input logic [NUM_CH*3-1:0]       cfg_mode_o,
  input logic [NUM_CH-1:0]         cfg_bcd_o
);
  localparam int LW = CW + 1;

  // R11
  ctrl_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd3) |-> (rdata == 8'hFF));

  // R3
  load_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_o));

  // R3
  ctrl_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3) |=> (load_o == '0));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R5
    load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_o[i] |-> (load_val_o[i*LW +: LW] != '0));

    // R2
    mode_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd3 && wdata[7:6] == 2'(i) && wdata[5:4] != 2'd0)
      |=> (cfg_mode_o[i*3 +: 3] == $past(wdata[3:1]) &&
           cfg_bcd_o[i] == $past(wdata[0])));
  end
endmodule

bind tmr_host_regs tmr_host_regs_chk #(.NUM_CH(NUM_CH), .CW(CW)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .addr       (addr),
  .wdata      (wdata),
  .rdata      (rdata),
  .load_o     (load_o),
  .load_val_o (load_val_o),
  .cfg_mode_o (cfg_mode_o),
  .cfg_bcd_o  (cfg_bcd_o)
);

// File: tb/test_tmr_host_regs.sv
module test_tmr_host_regs;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic        rd_en;
  logic [1:0]  addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic [47:0] cnt_i;
  logic [2:0]  out_lvl_i;
  logic [2:0]  load_o;
  logic [50:0] load_val_o;
  logic [8:0]  cfg_mode_o;
  logic [2:0]  cfg_bcd_o;

  int n_tests;
  int n_fail;

  logic [2:0]  ld_seen;
  logic [50:0] ldv_seen;
  logic [7:0]  rd_byte;

  tmr_host_regs i_tmr_host_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cnt_i(cnt_i), .out_lvl_i(out_lvl_i),
    .load_o(load_o), .load_val_o(load_val_o), .cfg_mode_o(cfg_mode_o),
    .cfg_bcd_o(cfg_bcd_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    ld_seen  = load_o;
    ldv_seen = load_val_o;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 rd_byte = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_cnt(input int ch, input logic [15:0] v);
    cnt_i[ch*16 +: 16] = v;
  endtask

  task automatic t_reset;
    check("R1 no load", 32'(load_o), 32'h0);
    check("R1 mode ch0", 32'(cfg_mode_o[2:0]), 32'h3);
    check("R1 bcd", 32'(cfg_bcd_o), 32'h0);
    set_cnt(0, 16'h1234);
    rd(2'd0); check("R1/R10 low first", 32'(rd_byte), 32'h34);
    rd(2'd0); check("R1/R10 high next", 32'(rd_byte), 32'h12);
  endtask

  task automatic t_single_byte;
    wr(2'd3, 8'h15);  // ch0, low only, mode 2, bcd
    check("R2 mode", 32'(cfg_mode_o[2:0]), 32'h2);
    check("R2 bcd", 32'(cfg_bcd_o[0]), 32'h1);
    check("R2 no load on control", 32'(ld_seen), 32'h0);
    wr(2'd0, 8'h55);
    check("R3 low strobe", 32'(ld_seen), 32'h1);
    check("R3 low value", ldv_seen[16:0], 32'h55);
    wr(2'd3, 8'h64);  // ch1, high only, mode 2
    wr(2'd1, 8'hAB);
    check("R3 high strobe", 32'(ld_seen), 32'h2);
    check("R3 high value", ldv_seen[33:17], 32'hAB00);
    wr(2'd0, 8'h00);
    check("R5 low-only zero", ldv_seen[16:0], 32'h10000);
  endtask

  task automatic t_word;
    wr(2'd3, 8'hB6);  // ch2, word, mode 3
    wr(2'd2, 8'h34);
    check("R4 first byte no strobe", 32'(ld_seen), 32'h0);
    wr(2'd2, 8'h12);
    check("R4 strobe", 32'(ld_seen), 32'h4);
    check("R4 value", ldv_seen[50:34], 32'h1234);
    wr(2'd2, 8'h00);
    wr(2'd2, 8'h00);
    check("R5 word zero", ldv_seen[50:34], 32'h10000);
  endtask

  task automatic t_read_seq;
    set_cnt(0, 16'h1234);
    set_cnt(1, 16'hBEEF);
    set_cnt(2, 16'hCAFE);
    rd(2'd0); check("R10 low only a", 32'(rd_byte), 32'h34);
    rd(2'd0); check("R10 low only b", 32'(rd_byte), 32'h34);
    rd(2'd1); check("R10 high only a", 32'(rd_byte), 32'hBE);
    rd(2'd1); check("R10 high only b", 32'(rd_byte), 32'hBE);
    wr(2'd3, 8'hB6);
    wr(2'd2, 8'h78);  // half a word write
    rd(2'd2); check("R10 word low", 32'(rd_byte), 32'hFE);
    rd(2'd2); check("R10 word high", 32'(rd_byte), 32'hCA);
    rd(2'd2); check("R10 word low again", 32'(rd_byte), 32'hFE);
    wr(2'd2, 8'h56);
    check("R10 write seq independent", ldv_seen[50:34], 32'h5678);
  endtask

  task automatic t_latch;
    wr(2'd3, 8'hB6);
    set_cnt(2, 16'h5678);
    wr(2'd3, 8'h80);  // latch ch2
    set_cnt(2, 16'h9999);
    wr(2'd3, 8'h80);  // ignored while pending
    rd(2'd2); check("R6/R7 latched low", 32'(rd_byte), 32'h78);
    rd(2'd2); check("R6/R7 latched high", 32'(rd_byte), 32'h56);
    rd(2'd2); check("R6 released live", 32'(rd_byte), 32'h99);
  endtask

  task automatic t_readback;
    set_cnt(0, 16'h1111);
    set_cnt(1, 16'h2222);
    out_lvl_i = 3'b001;
    wr(2'd3, 8'hC6);  // count + status, ch0 and ch1
    out_lvl_i = 3'b000;
    wr(2'd3, 8'hE2);  // status only ch0: must not overwrite
    set_cnt(0, 16'h3333);
    set_cnt(1, 16'h4444);
    rd(2'd0); check("R9 status ch0", 32'(rd_byte), 32'h95);
    rd(2'd0); check("R8 latched ch0", 32'(rd_byte), 32'h11);
    rd(2'd0); check("R8 released ch0", 32'(rd_byte), 32'h33);
    rd(2'd1); check("R9 status ch1", 32'(rd_byte), 32'h24);
    rd(2'd1); check("R8 latched ch1", 32'(rd_byte), 32'h22);
    rd(2'd1); check("R8 released ch1", 32'(rd_byte), 32'h44);
  endtask

  task automatic t_ctrl_read;
    rd(2'd3); check("R11 control read", 32'(rd_byte), 32'hFF);
  endtask

  initial begin
    #800000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests = 0; n_fail = 0;
    wr_en = 1'b0; rd_en = 1'b0; addr = 2'd0; wdata = 8'h0;
    cnt_i = '0; out_lvl_i = '0;
    ld_seen = '0; ldv_seen = '0; rd_byte = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_byte();
    t_word();
    t_read_seq();
    t_latch();
    t_readback();
    t_ctrl_read();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule